// File: doc/BRIEF.md
# Stereo Interlaced Video Timing Generator

This block produces the sync, data-enable and position signals for a parallel pixel output. It runs in the pixel clock domain. A line is built from four horizontal segments: sync pulse, back porch, active pixels and front porch. A field is built the same way, but counted in lines. The horizontal and vertical lengths come straight from configuration pins, which an outer register block holds.

Frames can be progressive, interlaced, or stereo frame-packed, and stereo can be combined with interlace. The block steps through up to four field slots. Each slot has its own vertical sync width, back porch, front porch and a half-line flag. When that flag is set, the slot's vertical sync starts and ends in the middle of a line instead of at its start.

Every sync and enable output has its own polarity pin. A software reset holds the counters while software reprograms the block. A run enable stops output activity at the next line boundary. There is no pixel stream in this block, so every pin is a plain level: there is no valid/ready handshake and no back-pressure.

Top module: `vid_timing_gen`

## Requirements
- R1: A line lasts `h_sync_w + h_back + h_active + h_front` pixel clocks. Horizontal sync is asserted for the first `h_sync_w` clocks of the line, that is, at positions 0 to `h_sync_w - 1`. The active pixels follow the back porch.
- R2: A field lasts `v_sync_w[s] + v_back[s] + v_active + v_front[s]` lines, where `s` is the current slot. Vertical sync covers the first `v_sync_w[s]` lines, and the active lines follow that slot's back porch. The slot index is 0 = left odd, 1 = left even, 2 = right odd, 3 = right even.
- R3: Fields are produced in the order slot 0, 1, 2, 3, skipping any slot whose mode is off. With interlace off there are no even slots; with stereo off there are no right slots. `field_o` is 1 for an even field and `eye_o` is 1 for the right eye. Both change on the first clock of a field and are 0 while idle.
- R4: When `v_half[s]` is set, both edges of vertical sync move to line position `floor(line_total/2)`. Sync then runs from the middle of line 0 to the middle of line `v_sync_w[s]`.
- R5: Data enable is asserted only when both the horizontal and the vertical position are in their active regions. `x_o` and `y_o` count from 0 at the first active pixel and the first active line, and are 0 whenever data enable is inactive.
- R6: Each of `hs_o`, `vs_o` and `de_o` equals its active sense XOR its polarity pin, so a polarity of 1 gives an active-low output. `ck_fall_o` follows `pol_ck` one clock later and selects the falling clock edge for the output.
- R7: While `soft_rst` is high, the counters are cleared and every output is at its inactive level from the next clock edge on. After release with `run_en` high, the first line of slot 0 appears on the outputs at the second rising edge.
- R8: When `run_en` goes low, the current line still completes. Every output is then inactive. When `run_en` is raised again, timing restarts at line 0 of slot 0, with the same two-edge latency as in R7.
- R9: While `rst_n` is low, all outputs are 0 and all state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Software reset; holds the counters while configuring |
| run_en | input | 1 | Global run enable; takes effect at line boundaries |
| il_en | input | 1 | Interlace enable (adds even fields) |
| st_en | input | 1 | Stereo frame-packing enable (adds right-eye fields) |
| h_sync_w | input | HW | Horizontal sync width in clocks |
| h_back | input | HW | Horizontal back porch in clocks |
| h_active | input | HW | Active pixels per line |
| h_front | input | HW | Horizontal front porch in clocks |
| v_sync_w | input | 4 x VW | Vertical sync width in lines, one per slot |
| v_back | input | 4 x VW | Vertical back porch in lines, one per slot |
| v_front | input | 4 x VW | Vertical front porch in lines, one per slot |
| v_half | input | 4 | Half-line vsync shift flag, one per slot |
| v_active | input | VW | Active lines per field (already halved for interlace) |
| pol_hs | input | 1 | Horizontal sync polarity |
| pol_vs | input | 1 | Vertical sync polarity |
| pol_de | input | 1 | Data enable polarity |
| pol_ck | input | 1 | Output clock edge select |
| hs_o | output | 1 | Horizontal sync |
| vs_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| ck_fall_o | output | 1 | Registered clock edge select |
| field_o | output | 1 | Field parity (1 = even) |
| eye_o | output | 1 | Eye (1 = right) |
| x_o | output | HW | Active pixel column |
| y_o | output | VW | Active line within the field |

## Verification
The assertions rely on two conditions about the inputs. First, configuration and polarity pins change only while `soft_rst` is high, and `soft_rst` stays high across the release of `rst_n`. Second, the blanking part of each line (`h_sync_w + h_back + h_front`) is non-zero, so two consecutive active clocks always belong to the same line. The bench changes every setting inside a software-reset window that opens before the first clock after reset. Every table entry has non-zero horizontal sync and porches.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int NSLOT = 4;

  // Field slot: {eye, parity}; index 0 LO, 1 LE, 2 RO, 3 RE
  typedef struct packed {
    logic eye;
    logic par;
  } slot_t;

  function automatic slot_t vtg_next_slot(slot_t cur, logic il, logic st);
    slot_t n;
    if (il && !cur.par) begin
      n.eye = cur.eye;
      n.par = 1'b1;
    end else begin
      n.par = 1'b0;
      n.eye = st && !cur.eye;
    end
    return n;
  endfunction
endpackage

// File: rtl/vtg_hcount.sv
module vtg_hcount #(
  parameter int HW = 12,
  localparam int CW = HW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  input  logic [HW-1:0] sync_w,
  input  logic [HW-1:0] back_p,
  input  logic [HW-1:0] act_w,
  input  logic [HW-1:0] front_p,
  output logic [CW-1:0] pos,
  output logic [CW-1:0] half,
  output logic          last,
  output logic          sync_on,
  output logic          act_on,
  output logic [HW-1:0] xpos
);
  logic [CW-1:0] total, act_lo;

  assign total   = CW'(sync_w) + CW'(back_p) + CW'(act_w) + CW'(front_p);
  assign act_lo  = CW'(sync_w) + CW'(back_p);
  assign half    = total >> 1;
  assign last    = (pos == total - 1'b1);
  assign sync_on = (pos < CW'(sync_w));
  assign act_on  = (pos >= act_lo) && (pos < act_lo + CW'(act_w));
  assign xpos    = HW'(pos - act_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pos <= '0;
    else if (clr)     pos <= '0;
    else if (adv)     pos <= last ? '0 : pos + 1'b1;
  end
endmodule

// File: rtl/vtg_vcount.sv
module vtg_vcount #(
  parameter int VW = 11,
  parameter int CW = 14,
  localparam int LW = VW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [CW-1:0] hpos,
  input  logic [CW-1:0] half,
  input  logic [VW-1:0] sync_w,
  input  logic [VW-1:0] back_p,
  input  logic [VW-1:0] act_h,
  input  logic [VW-1:0] front_p,
  input  logic          shift,
  output logic          last,
  output logic          sync_on,
  output logic          act_on,
  output logic [VW-1:0] ypos
);
  logic [LW-1:0] line, total, act_lo;
  logic          pre_half, plain_on, shift_on;

  assign total    = LW'(sync_w) + LW'(back_p) + LW'(act_h) + LW'(front_p);
  assign act_lo   = LW'(sync_w) + LW'(back_p);
  assign last     = (line == total - 1'b1);
  assign pre_half = (hpos < half);
  assign plain_on = (line < LW'(sync_w));
  // Shifted window: from mid line 0 to mid line sync_w
  assign shift_on = (plain_on && !(line == '0 && pre_half)) ||
                    ((sync_w != '0) && (line == LW'(sync_w)) && pre_half);
  assign sync_on  = shift ? shift_on : plain_on;
  assign act_on   = (line >= act_lo) && (line < act_lo + LW'(act_h));
  assign ypos     = VW'(line - act_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    line <= '0;
    else if (clr)  line <= '0;
    else if (step) line <= last ? '0 : line + 1'b1;
  end
endmodule

// File: rtl/vtg_field_seq.sv
module vtg_field_seq
  import vtg_pkg::*;
#(
  parameter int VW = 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       adv,
  input  logic                       il_en,
  input  logic                       st_en,
  input  logic [NSLOT-1:0][VW-1:0]   sw_set,
  input  logic [NSLOT-1:0][VW-1:0]   bp_set,
  input  logic [NSLOT-1:0][VW-1:0]   fp_set,
  input  logic [NSLOT-1:0]           shift_set,
  output slot_t                      slot,
  output logic [VW-1:0]              sw,
  output logic [VW-1:0]              bp,
  output logic [VW-1:0]              fp,
  output logic                       shift
);
  logic [1:0] idx;

  assign idx   = slot;
  assign sw    = sw_set[idx];
  assign bp    = bp_set[idx];
  assign fp    = fp_set[idx];
  assign shift = shift_set[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    slot <= '0;
    else if (clr)  slot <= '0;
    else if (adv)  slot <= vtg_next_slot(slot, il_en, st_en);
  end
endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
  import vtg_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     soft_rst,
  input  logic                     run_en,
  input  logic                     il_en,
  input  logic                     st_en,
  input  logic [HW-1:0]            h_sync_w,
  input  logic [HW-1:0]            h_back,
  input  logic [HW-1:0]            h_active,
  input  logic [HW-1:0]            h_front,
  input  logic [NSLOT-1:0][VW-1:0] v_sync_w,
  input  logic [NSLOT-1:0][VW-1:0] v_back,
  input  logic [NSLOT-1:0][VW-1:0] v_front,
  input  logic [NSLOT-1:0]         v_half,
  input  logic [VW-1:0]            v_active,
  input  logic                     pol_hs,
  input  logic                     pol_vs,
  input  logic                     pol_de,
  input  logic                     pol_ck,
  output logic                     hs_o,
  output logic                     vs_o,
  output logic                     de_o,
  output logic                     ck_fall_o,
  output logic                     field_o,
  output logic                     eye_o,
  output logic [HW-1:0]            x_o,
  output logic [VW-1:0]            y_o
);
  localparam int CW = HW + 2;

  logic          live, run_now, h_last, hs_on, hde_on;
  logic          v_last, vs_on, vde_on, shift_sel, de_on;
  logic          h_clr, v_clr, v_step, f_adv;
  logic [CW-1:0] hpos, hhalf;
  logic [HW-1:0] xpos;
  logic [VW-1:0] ypos, vsw_sel, vbp_sel, vfp_sel;
  slot_t         slot;

  assign run_now = live & ~soft_rst;
  assign h_clr   = soft_rst | ~live;
  assign v_step  = live & h_last & run_en;
  assign v_clr   = soft_rst | ~live | (h_last & ~run_en);
  assign f_adv   = v_step & v_last;
  assign de_on   = hde_on & vde_on;

  // Run state: sampled while idle and at every line end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              live <= 1'b0;
    else if (soft_rst)       live <= 1'b0;
    else if (!live || h_last) live <= run_en;
  end

  vtg_hcount #(.HW(HW)) u_h (
    .clk(clk), .rst_n(rst_n), .clr(h_clr), .adv(live),
    .sync_w(h_sync_w), .back_p(h_back), .act_w(h_active), .front_p(h_front),
    .pos(hpos), .half(hhalf), .last(h_last), .sync_on(hs_on), .act_on(hde_on),
    .xpos(xpos)
  );

  vtg_field_seq #(.VW(VW)) u_seq (
    .clk(clk), .rst_n(rst_n), .clr(v_clr), .adv(f_adv),
    .il_en(il_en), .st_en(st_en),
    .sw_set(v_sync_w), .bp_set(v_back), .fp_set(v_front), .shift_set(v_half),
    .slot(slot), .sw(vsw_sel), .bp(vbp_sel), .fp(vfp_sel), .shift(shift_sel)
  );

  vtg_vcount #(.VW(VW), .CW(CW)) u_v (
    .clk(clk), .rst_n(rst_n), .clr(v_clr), .step(v_step),
    .hpos(hpos), .half(hhalf),
    .sync_w(vsw_sel), .back_p(vbp_sel), .act_h(v_active), .front_p(vfp_sel),
    .shift(shift_sel), .last(v_last), .sync_on(vs_on), .act_on(vde_on),
    .ypos(ypos)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_o      <= 1'b0;
      vs_o      <= 1'b0;
      de_o      <= 1'b0;
      ck_fall_o <= 1'b0;
      field_o   <= 1'b0;
      eye_o     <= 1'b0;
      x_o       <= '0;
      y_o       <= '0;
    end else begin
      hs_o      <= pol_hs ^ (run_now & hs_on);
      vs_o      <= pol_vs ^ (run_now & vs_on);
      de_o      <= pol_de ^ (run_now & de_on);
      ck_fall_o <= pol_ck;
      field_o   <= run_now & slot.par;
      eye_o     <= run_now & slot.eye;
      x_o       <= (run_now & de_on) ? xpos : '0;
      y_o       <= (run_now & de_on) ? ypos : '0;
    end
  end
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          soft_rst,
  input logic          il_en,
  input logic          st_en,
  input logic          pol_hs,
  input logic          pol_vs,
  input logic          pol_de,
  input logic          hs_o,
  input logic          vs_o,
  input logic          de_o,
  input logic          field_o,
  input logic          eye_o,
  input logic [HW-1:0] x_o,
  input logic [VW-1:0] y_o
);
  logic de_act, hs_act;
  assign de_act = de_o ^ pol_de;
  assign hs_act = hs_o ^ pol_hs;

  AST_SRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (hs_o == $past(pol_hs) && vs_o == $past(pol_vs) && de_o == $past(pol_de))); // R7

  AST_DE_OUTSIDE_SYNC: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    de_act |-> !hs_act); // R1

  AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (de_act && $past(de_act)) |-> (x_o == $past(x_o) + 1'b1)); // R5

  AST_Y_HOLD: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (de_act && $past(de_act)) |-> (y_o == $past(y_o))); // R5

  AST_NO_EVEN_PROG: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    !il_en |-> !field_o); // R3

  AST_NO_RIGHT_MONO: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    !st_en |-> !eye_o); // R3

  AST_RIGHT_STARTS_ODD: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    $rose(eye_o) |-> !field_o); // R3
endmodule

bind vid_timing_gen vtg_checker #(.HW(HW), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .il_en(il_en), .st_en(st_en),
  .pol_hs(pol_hs), .pol_vs(pol_vs), .pol_de(pol_de),
  .hs_o(hs_o), .vs_o(vs_o), .de_o(de_o), .field_o(field_o), .eye_o(eye_o),
  .x_o(x_o), .y_o(y_o)
);

// File: tb/tb_vid_timing_gen.sv
`timescale 1ns/1ps
module tb_vid_timing_gen;
  localparam int HW = 12;
  localparam int VW = 11;

  typedef struct packed {
    logic       il;
    logic       st;
    logic [3:0] half;
    logic [3:0] pol;   // {ck, de, vs, hs}
    logic [7:0] hsw, hbp, hact, hfp;
    logic [7:0] vsw, vbp, vact, vfp;
    logic [15:0] cyc;
  } cfg_t;

  // Per slot s the bench programs vsw+s, vbp+(s>>1), vfp+s
  localparam cfg_t TBL [5] = '{
    '{1'b0, 1'b0, 4'b0000, 4'b0000, 8'd2, 8'd3, 8'd6, 8'd2, 8'd1, 8'd2, 8'd3, 8'd1, 16'd800},
    '{1'b1, 1'b0, 4'b0010, 4'b0011, 8'd3, 8'd2, 8'd5, 8'd3, 8'd2, 8'd1, 8'd4, 8'd2, 16'd1200},
    '{1'b0, 1'b1, 4'b0000, 4'b1100, 8'd1, 8'd1, 8'd4, 8'd1, 8'd1, 8'd1, 8'd2, 8'd1, 16'd800},
    '{1'b1, 1'b1, 4'b1010, 4'b1111, 8'd2, 8'd2, 8'd7, 8'd3, 8'd1, 8'd2, 8'd3, 8'd2, 16'd2000},
    '{1'b1, 1'b0, 4'b0011, 4'b0000, 8'd1, 8'd2, 8'd4, 8'd2, 8'd2, 8'd1, 8'd2, 8'd1, 16'd800}
  };

  logic clk = 1'b0;
  logic rst_n, soft_rst, run_en, il_en, st_en;
  logic [HW-1:0] h_sync_w, h_back, h_active, h_front;
  logic [3:0][VW-1:0] v_sync_w, v_back, v_front;
  logic [3:0] v_half;
  logic [VW-1:0] v_active;
  logic pol_hs, pol_vs, pol_de, pol_ck;
  logic hs_o, vs_o, de_o, ck_fall_o, field_o, eye_o;
  logic [HW-1:0] x_o;
  logic [VW-1:0] y_o;

  int nchk = 0;
  int nerr = 0;
  bit chk_on = 0;

  always #5 clk = ~clk;

  vid_timing_gen #(.HW(HW), .VW(VW)) dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .run_en(run_en),
    .il_en(il_en), .st_en(st_en),
    .h_sync_w(h_sync_w), .h_back(h_back), .h_active(h_active), .h_front(h_front),
    .v_sync_w(v_sync_w), .v_back(v_back), .v_front(v_front), .v_half(v_half),
    .v_active(v_active),
    .pol_hs(pol_hs), .pol_vs(pol_vs), .pol_de(pol_de), .pol_ck(pol_ck),
    .hs_o(hs_o), .vs_o(vs_o), .de_o(de_o), .ck_fall_o(ck_fall_o),
    .field_o(field_o), .eye_o(eye_o), .x_o(x_o), .y_o(y_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model of the timing, built from the requirements
  int m_h, m_v, m_slot;
  bit m_live;
  int e_hs, e_vs, e_de, e_ck, e_field, e_eye, e_x, e_y;
  bit e_sh;

  always @(posedge clk) begin : model
    int ht, vs, vb, va, vf, vt, hf, hlo, vlo;
    bit run, hsa, vsa, dea, sh;
    if (!rst_n) begin
      m_live = 0; m_h = 0; m_v = 0; m_slot = 0;
      e_hs = 0; e_vs = 0; e_de = 0; e_ck = 0; e_field = 0; e_eye = 0; e_x = 0; e_y = 0;
      e_sh = 0;
    end else begin
      ht  = h_sync_w + h_back + h_active + h_front;
      vs  = v_sync_w[m_slot];
      vb  = v_back[m_slot];
      va  = v_active;
      vf  = v_front[m_slot];
      vt  = vs + vb + va + vf;
      hf  = ht / 2;
      sh  = v_half[m_slot];
      hlo = h_sync_w + h_back;
      vlo = vs + vb;
      run = m_live && !soft_rst;
      hsa = m_h < h_sync_w;
      if (sh) vsa = (m_v < vs && !(m_v == 0 && m_h < hf)) || (vs != 0 && m_v == vs && m_h < hf);
      else    vsa = m_v < vs;
      dea = m_h >= hlo && m_h < hlo + h_active && m_v >= vlo && m_v < vlo + va;
      e_hs    = pol_hs ^ (run && hsa);
      e_vs    = pol_vs ^ (run && vsa);
      e_de    = pol_de ^ (run && dea);
      e_ck    = pol_ck;
      e_field = run ? m_slot % 2 : 0;
      e_eye   = run ? m_slot / 2 : 0;
      e_x     = (run && dea) ? m_h - hlo : 0;
      e_y     = (run && dea) ? m_v - vlo : 0;
      e_sh    = sh;
      if (soft_rst) begin
        m_live = 0; m_h = 0; m_v = 0; m_slot = 0;
      end else if (!m_live) begin
        m_h = 0; m_v = 0; m_slot = 0; m_live = run_en;
      end else if (m_h == ht - 1) begin
        m_h = 0;
        if (!run_en) begin
          m_live = 0; m_v = 0; m_slot = 0;
        end else if (m_v == vt - 1) begin
          m_v = 0;
          if (il_en && m_slot % 2 == 0) m_slot = m_slot + 1;
          else m_slot = (st_en && m_slot / 2 == 0) ? 2 : 0;
        end else begin
          m_v = m_v + 1;
        end
      end else begin
        m_h = m_h + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      chk("R1 hsync", hs_o, e_hs);
      chk(e_sh ? "R4 half-line vsync" : "R2 vsync", vs_o, e_vs);
      chk("R5 data enable", de_o, e_de);
      chk("R5 x position", x_o, e_x);
      chk("R5 y position", y_o, e_y);
      chk("R3 field parity", field_o, e_field);
      chk("R3 eye", eye_o, e_eye);
      chk("R6 clock edge select", ck_fall_o, e_ck);
    end
  end

  task automatic apply_cfg(input cfg_t c);
    @(negedge clk);
    soft_rst = 1'b1;
    run_en   = 1'b0;
    il_en    = c.il;
    st_en    = c.st;
    h_sync_w = HW'(c.hsw);
    h_back   = HW'(c.hbp);
    h_active = HW'(c.hact);
    h_front  = HW'(c.hfp);
    v_active = VW'(c.vact);
    v_half   = c.half;
    {pol_ck, pol_de, pol_vs, pol_hs} = c.pol;
    for (int s = 0; s < 4; s++) begin
      v_sync_w[s] = VW'(c.vsw + s);
      v_back[s]   = VW'(c.vbp + (s >> 1));
      v_front[s]  = VW'(c.vfp + s);
    end
    @(negedge clk);
    soft_rst = 1'b0;
    run_en   = 1'b1;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin : stim
    rst_n = 1'b0; soft_rst = 1'b1; run_en = 1'b0; il_en = 1'b0; st_en = 1'b0;
    h_sync_w = '0; h_back = '0; h_active = '0; h_front = '0;
    v_sync_w = '0; v_back = '0; v_front = '0; v_half = '0; v_active = '0;
    pol_hs = 1'b0; pol_vs = 1'b0; pol_de = 1'b0; pol_ck = 1'b0;
    repeat (3) @(negedge clk);
    // R9: hard reset state
    chk("R9 reset hsync", hs_o, 0);
    chk("R9 reset vsync", vs_o, 0);
    chk("R9 reset de", de_o, 0);
    chk("R9 reset clock edge", ck_fall_o, 0);
    chk("R9 reset field", field_o, 0);
    chk("R9 reset eye", eye_o, 0);
    chk("R9 reset x", x_o, 0);
    chk("R9 reset y", y_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_on = 1;

    for (int i = 0; i < 5; i++) begin
      apply_cfg(TBL[i]);
      repeat (TBL[i].cyc) @(negedge clk);
    end

    // R7: software reset mid-run, then restart latency
    apply_cfg(TBL[0]);
    repeat (40) @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    chk("R7 hsync idle in soft reset", hs_o, 0);
    chk("R7 de idle in soft reset", de_o, 0);
    chk("R7 x cleared in soft reset", x_o, 0);
    soft_rst = 1'b0;
    @(negedge clk);
    chk("R7 no sync one edge after release", hs_o, 0);
    @(negedge clk);
    chk("R7 first sync two edges after release", hs_o, 1);
    chk("R7 first field is left odd", field_o + 2 * eye_o, 0);

    // R8: stop at line boundary, then restart from slot 0
    repeat (30) @(negedge clk);
    run_en = 1'b0;
    repeat (15) @(negedge clk);
    for (int k = 0; k < 39; k++) begin
      chk("R8 idle de after stop", de_o, 0);
      chk("R8 idle hsync after stop", hs_o, 0);
      @(negedge clk);
    end
    run_en = 1'b1;
    @(negedge clk);
    chk("R8 still idle one edge after restart", hs_o, 0);
    @(negedge clk);
    chk("R8 restart hsync", hs_o, 1);
    chk("R8 restart field", field_o, 0);

    // R6: inverted idle levels under soft reset
    @(negedge clk);
    soft_rst = 1'b1;
    pol_hs = 1'b1; pol_de = 1'b1; pol_ck = 1'b1;
    @(negedge clk);
    chk("R6 inverted hsync idle level", hs_o, 1);
    chk("R6 inverted de idle level", de_o, 1);
    chk("R6 falling edge select", ck_fall_o, 1);
    @(negedge clk);
    chk_on = 0;
    summary();
    $finish;
  end
endmodule